// File: doc/BRIEF.md
# Redundant Thread Store Comparator

Two redundant hardware threads run the same program. Before any operation leaves the replicated region, this block checks the leading thread's copy against the trailing thread's copy. There are two such operations: committed stores, which carry an address and data, and uncached loads, which carry an address. Each thread pushes its entries into its own in-order queue. The two threads may reach the same entry many cycles apart. The block waits for the matching partner however long the gap is, then compares the two queue heads.

When the heads agree, the leading copy goes out on the cache-side port and both heads are dropped. When the heads disagree, a sticky fault flag is raised and nothing else is released until reset. Cached loads do not use this block; they go straight to the cache.

Top module: `dual_thread_store_checker`

## Requirements
- R1: When both queue heads are stores (kind bit 1) with equal address and equal data, the leading entry is offered on the output port with out_kind=1, and no fault is raised.
- R2: When both heads are uncached loads (kind bit 0), only the addresses are compared. A data difference is ignored, the pair is released, and out_data carries the leading copy's data.
- R3: A store pair with differing addresses sets fault on the next clock edge, and the pair is never offered on the output.
- R4: A store pair with equal addresses but differing data sets fault on the next clock edge, and the pair is never released.
- R5: A pair whose kind bits differ sets fault on the next clock edge, and the pair is never released.
- R6: Once fault is set, it stays set until reset and out_valid stays low, even if a later pair would match.
- R7: Entries are paired and released strictly in push order. A thread may run any number of entries ahead, up to the queue depth, and its entries wait for their partners without any time limit.
- R8: Each thread's queue holds DEPTH entries. While a queue holds DEPTH entries, that thread's ready output is low.
- R9: A pair is consumed only on a clock edge where out_valid and out_ready are both high. While out_ready is low, out_valid stays high and the out_* fields stay stable.
- R10: After reset, fault is low, out_valid is low, and both push ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading thread entry valid |
| lead_ready | output | 1 | Leading thread queue can accept |
| lead_kind | input | 1 | 1 = store, 0 = uncached load |
| lead_addr | input | ADDR_W | Leading entry address |
| lead_data | input | DATA_W | Leading entry data |
| trail_valid | input | 1 | Trailing thread entry valid |
| trail_ready | output | 1 | Trailing thread queue can accept |
| trail_kind | input | 1 | 1 = store, 0 = uncached load |
| trail_addr | input | ADDR_W | Trailing entry address |
| trail_data | input | DATA_W | Trailing entry data |
| out_valid | output | 1 | Checked entry available for the cache |
| out_ready | input | 1 | Cache side accepts the entry |
| out_kind | output | 1 | Kind of the released entry |
| out_addr | output | ADDR_W | Released address |
| out_data | output | DATA_W | Released data (leading copy) |
| fault | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with DEPTH=4 and 16-bit address and data. With a depth of four, a full queue and its stalled ready output are reached after only a few pushes. That makes it practical to fill the leading queue completely while the trailing queue stays empty, and then drain both under output back-pressure. The narrow fields keep the separate address, data and kind mismatch cases easy to construct, and each mismatch case runs after its own reset.

// File: rtl/dual_thread_store_checker.sv
module dual_thread_store_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_valid,
  output logic              lead_ready,
  input  logic              lead_kind,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [DATA_W-1:0] lead_data,
  input  logic              trail_valid,
  output logic              trail_ready,
  input  logic              trail_kind,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic [DATA_W-1:0] trail_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              fault
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 1 + ADDR_W + DATA_W;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [EW-1:0] lq [DEPTH];
  logic [EW-1:0] tq [DEPTH];
  logic [PW-1:0] lwp, lrp, twp, trp;
  logic [CW-1:0] lcnt, tcnt;
  logic          fault_q;

  logic lpush, tpush, pop, both, same;
  logic [EW-1:0] lh, th;

  assign lead_ready  = lcnt != FULL;
  assign trail_ready = tcnt != FULL;
  assign lpush = lead_valid && lead_ready;
  assign tpush = trail_valid && trail_ready;

  assign lh = lq[lrp];
  assign th = tq[trp];
  assign both = (lcnt != '0) && (tcnt != '0);
  assign same = (lh[EW-1] == th[EW-1]) &&
                (lh[EW-2:DATA_W] == th[EW-2:DATA_W]) &&
                (!lh[EW-1] || (lh[DATA_W-1:0] == th[DATA_W-1:0]));

  assign out_valid = both && same && !fault_q;
  assign pop       = out_valid && out_ready;
  assign out_kind  = lh[EW-1];
  assign out_addr  = lh[EW-2:DATA_W];
  assign out_data  = lh[DATA_W-1:0];
  assign fault     = fault_q;

  always_ff @(posedge clk) begin
    if (lpush) lq[lwp] <= {lead_kind, lead_addr, lead_data};
    if (tpush) tq[twp] <= {trail_kind, trail_addr, trail_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lwp <= '0; lrp <= '0; twp <= '0; trp <= '0;
      lcnt <= '0; tcnt <= '0;
      fault_q <= 1'b0;
    end else begin
      if (lpush) lwp <= (lwp == LAST) ? '0 : lwp + 1'b1;
      if (tpush) twp <= (twp == LAST) ? '0 : twp + 1'b1;
      if (pop) begin
        lrp <= (lrp == LAST) ? '0 : lrp + 1'b1;
        trp <= (trp == LAST) ? '0 : trp + 1'b1;
      end
      lcnt <= lcnt + CW'(lpush) - CW'(pop);
      tcnt <= tcnt + CW'(tpush) - CW'(pop);
      if (both && !same) fault_q <= 1'b1;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R6
  AST_NO_RELEASE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !out_valid); // R6
  AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !same) |=> fault); // R3
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt == FULL || tcnt == FULL) |-> !(lead_ready && trail_ready)); // R8
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_kind))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt <= FULL) && (tcnt <= FULL)); // R8
endmodule

// File: tb/dual_thread_store_checker_tb.sv
module dual_thread_store_checker_tb_top;
  localparam int AW = 16, DW = 16, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic lead_valid = 0, lead_kind = 0, trail_valid = 0, trail_kind = 0, out_ready = 0;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0;
  logic [DW-1:0] lead_data = '0, trail_data = '0;
  logic lead_ready, trail_ready, out_valid, out_kind, fault;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [AW+DW:0] expq [$];

  always #2.5 clk = ~clk;

  dual_thread_store_checker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lead_valid(lead_valid), .lead_ready(lead_ready), .lead_kind(lead_kind),
    .lead_addr(lead_addr), .lead_data(lead_data),
    .trail_valid(trail_valid), .trail_ready(trail_ready), .trail_kind(trail_kind),
    .trail_addr(trail_addr), .trail_data(trail_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_data(out_data), .fault(fault));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_lead(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_out);
    @(posedge clk); #1;
    lead_valid = 1; lead_kind = k; lead_addr = a; lead_data = d;
    forever begin @(negedge clk); if (lead_ready) break; end
    @(posedge clk); #1;
    lead_valid = 0;
    if (expect_out) expq.push_back({k, a, d});
  endtask

  task automatic push_trail(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    trail_valid = 1; trail_kind = k; trail_addr = a; trail_data = d;
    forever begin @(negedge clk); if (trail_ready) break; end
    @(posedge clk); #1;
    trail_valid = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each release against the scoreboard (R1 R2 R7)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R7 unexpected release", out_addr, 0);
      else begin
        chk({out_kind, out_addr, out_data} == expq[0], "R1/R2/R7 released entry",
            {out_kind, out_addr, out_data}, expq[0]);
        void'(expq.pop_front());
      end
    end
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    wait_neg(1);
    // R10 reset state
    chk(fault == 0, "R10 fault", fault, 0);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(lead_ready && trail_ready, "R10 ready", {lead_ready, trail_ready}, 2'b11);

    // R7 skew: leading thread runs ahead, trailing thread arrives later
    out_ready = 1;
    for (int i = 0; i < 3; i++) push_lead(1, 16'h100 + 16'(i), 16'hA000 + 16'(i), 1);
    wait_neg(5);
    chk(out_valid == 0, "R7 waits for trailing partner", out_valid, 0);
    for (int i = 0; i < 3; i++) push_trail(1, 16'h100 + 16'(i), 16'hA000 + 16'(i));
    wait_neg(3);
    chk(expq.size() == 0, "R1 stores released in order", expq.size(), 0);
    chk(fault == 0, "R1 no fault on match", fault, 0);

    // R2 uncached load: data ignored, leading data forwarded
    push_lead(0, 16'h0F00, 16'h1111, 1);
    push_trail(0, 16'h0F00, 16'h2222);
    wait_neg(3);
    chk(expq.size() == 0, "R2 uncached load released", expq.size(), 0);
    chk(fault == 0, "R2 data ignored for loads", fault, 0);

    // R8 full queue, R9 back-pressure hold
    out_ready = 0;
    for (int i = 0; i < DEPTH; i++) push_lead(1, 16'h200 + 16'(i), 16'hB000 + 16'(i), 1);
    wait_neg(1);
    chk(lead_ready == 0, "R8 lead stalls when full", lead_ready, 0);
    chk(trail_ready == 1, "R8 trail still ready", trail_ready, 1);
    push_trail(1, 16'h200, 16'hB000);
    wait_neg(1);
    chk(out_valid == 1, "R9 valid under back-pressure", out_valid, 1);
    wait_neg(3);
    chk(out_valid == 1 && out_addr == 16'h200 && out_data == 16'hB000, "R9 held stable",
        {out_addr, out_data}, {16'h200, 16'hB000});
    chk(lead_ready == 0, "R9 nothing consumed without ready", lead_ready, 0);
    out_ready = 1;
    for (int i = 1; i < DEPTH; i++) push_trail(1, 16'h200 + 16'(i), 16'hB000 + 16'(i));
    wait_neg(3);
    chk(expq.size() == 0, "R7 drain after full", expq.size(), 0);
    chk(lead_ready == 1, "R8 ready after drain", lead_ready, 1);

    // R3 address mismatch
    do_reset();
    push_lead(1, 16'h300, 16'hC000, 0);
    push_trail(1, 16'h301, 16'hC000);
    wait_neg(2);
    chk(fault == 1, "R3 address mismatch fault", fault, 1);
    chk(out_valid == 0, "R3 no release", out_valid, 0);

    // R6 sticky, blocks later matching pairs (queues still hold the bad pair)
    push_lead(1, 16'h400, 16'hD000, 0);
    push_trail(1, 16'h400, 16'hD000);
    wait_neg(4);
    chk(fault == 1, "R6 fault sticky", fault, 1);
    chk(out_valid == 0, "R6 release blocked", out_valid, 0);

    // R4 data mismatch
    do_reset();
    wait_neg(1);
    chk(fault == 0, "R10 reset clears fault", fault, 0);
    push_lead(1, 16'h500, 16'hE000, 0);
    push_trail(1, 16'h500, 16'hE001);
    wait_neg(2);
    chk(fault == 1, "R4 data mismatch fault", fault, 1);
    chk(out_valid == 0, "R4 no release", out_valid, 0);

    // R5 kind mismatch
    do_reset();
    push_lead(1, 16'h600, 16'hF000, 0);
    push_trail(0, 16'h600, 16'hF000);
    wait_neg(2);
    chk(fault == 1, "R5 kind mismatch fault", fault, 1);
    chk(out_valid == 0, "R5 no release", out_valid, 0);

    chk(expq.size() == 0, "R7 scoreboard empty", expq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule